// File: doc/BRIEF.md
# Random Number Generator Control Register Block

This block is the software-facing front end of a random number generator peripheral. A processor reaches it over a simple register bus with a byte address, separate read and write strobes and 32-bit data. Through it, software starts a seeding pass or a self-test and programs the interrupt masks. It can read back the progress of both operations and pull 32-bit random words. One level-sensitive interrupt line tells software that an operation has finished.

The seed pass and the self-test are tracked separately. Each has a small state machine with three named states: IDLE, RUNNING and DONE. The transitions are:
- start: from any state to RUNNING, triggered by a start bit in a command write.
- finish: from RUNNING to DONE, once a programmable number of cycles has passed.
- restart: from RUNNING back to RUNNING with a fresh count, when the start bit is written again.
- flush: from any state to IDLE, on a soft reset.
- stay: in every other case the state holds.

The finish transition raises the interrupt unless completion interrupts are masked. The random words come from a 32-bit maximal-length linear feedback shift register. It stands in for a true entropy source.

Read data is registered. A read strobe in one cycle presents its word on the read data port after that clock edge, and the port then holds the word until the next read.

Top module: `rng_ctrl_regs`

## Requirements
- R1: A read of offset 0x00 returns the identity word 0x1000_0240: type 1 in bits [31:28], major revision 0x02 in bits [15:8] and minor revision 0x40 in bits [7:0].
- R2: After hardware reset, the interrupt is low, the read data port is 0, the command readback is 0, the control readback is 0 and the status word (offset 0x0C) is 0x0000_5541.
- R3: A command write (offset 0x04) with bit 1 set starts the seed pass. While it runs, command readback bit 1 is 1 and status bit 1 (busy) is 1 with status bit 0 (ready) at 0. It stays RUNNING for exactly OP_LAT cycles after the write edge, then enters DONE, where status bit 5 is 1.
- R4: A command write with bit 0 set starts the self-test with the same timing. Command readback bit 0 and busy show it running, and status bit 4 reports it done.
- R5: The finish transition of either operation sets the interrupt output in the same clock edge, unless control bit 5 (completion mask) is 1, in which case the interrupt is unchanged.
- R6: A command write with bit 4 (clear interrupt) or bit 5 (clear error) set lowers the interrupt.
- R7: Control bits 6 (error mask), 5 (completion mask) and 4 (auto-seed enable) are read/write. All other control bits read 0 whatever was written.
- R8: A command write with bit 6 set (soft reset) returns both operations to IDLE and clears the control register. A start bit in the same write still takes effect.
- R9: Writing a start bit to an operation that is already RUNNING restarts its count, so it finishes OP_LAT cycles after the latest start write.
- R10: Each read of offset 0x14 returns the current shift register word, which then advances. The register starts at LFSR_SEED (default 0xACE1_2468) and shifts left, with bit 0 taking the XOR of bits 31, 21, 1 and 0.
- R11: Reads of unmapped offsets (for example 0x10, 0x18, 0x40) return 0. Writes to the identity, status and random-word offsets change nothing, including the random sequence.
- R12: Status reports the FIFO size 5 in bits [15:12], the FIFO level 5 in bits [11:8] and new-seed-available (1) in bit 6. Ready is set exactly when busy is clear, and the error bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Level completion interrupt |

## Verification
A state machine stuck in the wrong state shows up on the first status or command read after the fault. Busy and ready both derive from the RUNNING states, so a missed finish transition keeps ready low indefinitely. A lost restart or an off-by-one count shows up only at the exact cycle boundary. For that reason the latency cases read status in the last RUNNING cycle and again in the first DONE cycle. A wrong interrupt decision is visible on the interrupt pin at the same edge as the finish transition. A shift register fault shows on the next random-word read.

// File: rtl/rng_pkg.sv
package rng_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_DONE = 2'd2
    } op_state_e;

    // register offsets (byte addresses)
    localparam int OFF_IDENT  = 'h00;
    localparam int OFF_CMD    = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_STATUS = 'h0C;
    localparam int OFF_RAND   = 'h14;

    // command bits; operation index i is started by bit i
    localparam int CMD_SOFT_RST = 6;
    localparam int CMD_CLR_ERR  = 5;
    localparam int CMD_CLR_IRQ  = 4;

    // control bits
    localparam int CTL_MASK_ERR  = 6;
    localparam int CTL_MASK_DONE = 5;
    localparam int CTL_AUTO_SEED = 4;

    // operation indices
    localparam int OP_SELFTEST = 0;
    localparam int OP_SEED     = 1;
    localparam int OP_NUM      = 2;

    localparam logic [31:0] IDENT_WORD = {4'h1, 12'h000, 8'h02, 8'h40};

endpackage

// File: rtl/rng_op_fsm.sv
module rng_op_fsm
    import rng_pkg::*;
#(
    parameter int LAT = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      flush_i,
    output op_state_e state_o,
    output logic      done_o
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

    op_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: start beats flush, flush beats finish
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start_i) begin
            state_d = OP_RUN;
            cnt_d   = CNT_LOAD;
        end else if (flush_i) begin
            state_d = OP_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                OP_IDLE: ;
                OP_RUN: begin
                    if (cnt_q == '0) state_d = OP_DONE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                OP_DONE: ;
                default: state_d = OP_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        done_o  = (state_q == OP_RUN) && (cnt_q == '0) && !start_i && !flush_i;
    end

    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == OP_RUN));

    p_finish_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == OP_DONE));

    p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !start_i) |=> (state_q == OP_IDLE));

endmodule

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = 32'hACE1_2468,
    parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sr_q;
    logic         fb;

    always_comb fb = ^(sr_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr_q <= SEED;
        else if (adv_i) sr_q <= {sr_q[W-2:0], fb};
    end

    always_comb word_o = sr_q;

    p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(sr_q));

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
    import rng_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          OP_LAT     = 16,
    parameter int          FIFO_WORDS = 5,
    parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam logic [3:0] FIFO_CODE = 4'(FIFO_WORDS);

    logic              wr_cmd, wr_ctrl, rd_rand, soft_rst, clr_irq;
    logic [OP_NUM-1:0] start, done, running, finished;
    op_state_e         op_st [OP_NUM];
    logic              mask_err_q, mask_done_q, auto_seed_q;
    logic [31:0]       rand_word, rd_mux, rdata_q, status_w, ctrl_w;
    logic              irq_q;

    always_comb begin
        wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
        wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
        rd_rand  = bus_rd && (bus_addr == ADDR_W'(OFF_RAND));
        soft_rst = wr_cmd && bus_wdata[CMD_SOFT_RST];
        clr_irq  = wr_cmd && (bus_wdata[CMD_CLR_IRQ] || bus_wdata[CMD_CLR_ERR]);
    end

    // one state machine per operation
    for (genvar i = 0; i < OP_NUM; i++) begin : g_op
        assign start[i] = wr_cmd && bus_wdata[i];
        rng_op_fsm #(.LAT(OP_LAT)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start[i]),
            .flush_i (soft_rst),
            .state_o (op_st[i]),
            .done_o  (done[i])
        );
        assign running[i]  = (op_st[i] == OP_RUN);
        assign finished[i] = (op_st[i] == OP_DONE);
    end

    rng_lfsr #(.W(32), .SEED(LFSR_SEED)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (rd_rand),
        .word_o (rand_word)
    );

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_err_q  <= 1'b0;
            mask_done_q <= 1'b0;
            auto_seed_q <= 1'b0;
        end else if (soft_rst) begin
            mask_err_q  <= 1'b0;
            mask_done_q <= 1'b0;
            auto_seed_q <= 1'b0;
        end else if (wr_ctrl) begin
            mask_err_q  <= bus_wdata[CTL_MASK_ERR];
            mask_done_q <= bus_wdata[CTL_MASK_DONE];
            auto_seed_q <= bus_wdata[CTL_AUTO_SEED];
        end
    end

    // interrupt: a completion beats a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       irq_q <= 1'b0;
        else if ((|done) && !mask_done_q) irq_q <= 1'b1;
        else if (clr_irq)                 irq_q <= 1'b0;
    end

    always_comb begin
        ctrl_w = '0;
        ctrl_w[CTL_MASK_ERR]  = mask_err_q;
        ctrl_w[CTL_MASK_DONE] = mask_done_q;
        ctrl_w[CTL_AUTO_SEED] = auto_seed_q;

        status_w        = '0;
        status_w[15:12] = FIFO_CODE;
        status_w[11:8]  = FIFO_CODE;
        status_w[6]     = 1'b1;
        status_w[5]     = finished[OP_SEED];
        status_w[4]     = finished[OP_SELFTEST];
        status_w[1]     = |running;
        status_w[0]     = ~(|running);
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_IDENT):  rd_mux = IDENT_WORD;
            ADDR_W'(OFF_CMD):    rd_mux = {{(32-OP_NUM){1'b0}}, running};
            ADDR_W'(OFF_CTRL):   rd_mux = ctrl_w;
            ADDR_W'(OFF_STATUS): rd_mux = status_w;
            ADDR_W'(OFF_RAND):   rd_mux = rand_word;
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|done));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done) && mask_done_q && !clr_irq) |=> $stable(irq));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq && !(|done)) |=> !irq);

    p_ctrl_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!mask_err_q && !mask_done_q && !auto_seed_q));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/rng_ctrl_regs_tb.sv
module rng_ctrl_regs_tb_top;
    localparam int ADDR_W = 12;
    localparam int LAT    = 16;
    localparam logic [31:0] SEED = 32'hACE1_2468;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              irq;

    always #10 clk = ~clk; // 50 MHz

    rng_ctrl_regs #(.ADDR_W(ADDR_W), .OP_LAT(LAT), .LFSR_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model_sr = SEED;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issues a read and pushes the expected word into the scoreboard
    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_rand(input string tag);
        rd('h14, model_sr, tag);
        model_sr = lfsr_next(model_sr);
    endtask

    // monitor: pops the expected word when the registered data appears
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_run++; n_fail++;
                    $display("FAIL scoreboard: actual 0x%08h expected none", bus_rdata);
                end else begin
                    check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R2 reset state
        check({31'b0, irq}, 0, "R2 irq after reset");
        check(bus_rdata, 0, "R2 rdata after reset");
        rd('h04, 0, "R2 command readback");
        rd('h08, 0, "R2 control readback");
        rd('h0C, 32'h0000_5541, "R2/R12 status after reset");
        // R1 identity
        rd('h00, 32'h1000_0240, "R1 identity word");
        // R11 unmapped and read-only
        rd('h10, 0, "R11 unmapped 0x10");
        rd('h18, 0, "R11 unmapped 0x18");
        rd('h40, 0, "R11 unmapped 0x40");
        wr('h00, 32'hFFFF_FFFF);
        wr('h0C, 32'h0000_0000);
        rd('h00, 32'h1000_0240, "R11 identity after write");
        rd('h0C, 32'h0000_5541, "R11 status after write");
        // R10 random sequence
        rd_rand("R10 first word is seed");
        rd_rand("R10 second word");
        rd_rand("R10 third word");
        wr('h14, 32'h0);
        rd_rand("R11 random write ignored");
        // R12 read data holds
        wait_neg(3);
        check(bus_rdata, lfsr_next(lfsr_next(lfsr_next(SEED))), "R12 rdata holds between reads");
        // R7 control
        wr('h08, 32'hFFFF_FFFF);
        rd('h08, 32'h0000_0070, "R7 control all ones");
        wr('h08, 32'h0000_0010);
        rd('h08, 32'h0000_0010, "R7 control auto-seed only");
        wr('h08, 32'h0);
        rd('h08, 32'h0, "R7 control cleared");
        // R3 seed pass timing
        wr('h04, 32'h2);
        rd('h04, 32'h2, "R3 seed running in command");
        rd('h0C, 32'h0000_5542, "R3 busy while seeding");
        wait_neg(13);
        rd('h0C, 32'h0000_5542, "R3 last running cycle");
        rd('h0C, 32'h0000_5561, "R3 seed done");
        check({31'b0, irq}, 1, "R5 irq on seed done");
        rd('h04, 32'h0, "R3 command clear after done");
        // R6 clear interrupt
        wr('h04, 32'h10);
        check({31'b0, irq}, 0, "R6 clear interrupt bit");
        // R4 self-test
        wr('h04, 32'h1);
        rd('h04, 32'h1, "R4 self-test running in command");
        rd('h0C, 32'h0000_5562, "R4 busy while testing");
        wait_neg(13);
        rd('h0C, 32'h0000_5562, "R4 last running cycle");
        rd('h0C, 32'h0000_5571, "R4 self-test done");
        check({31'b0, irq}, 1, "R5 irq on self-test done");
        wr('h04, 32'h20);
        check({31'b0, irq}, 0, "R6 clear error bit");
        // R8 soft reset
        wr('h08, 32'h70);
        wr('h04, 32'h40);
        rd('h0C, 32'h0000_5541, "R8 operations idle after soft reset");
        rd('h08, 32'h0, "R8 control cleared by soft reset");
        check({31'b0, irq}, 0, "R8 irq untouched");
        wr('h08, 32'h50);
        wr('h04, 32'h42);
        rd('h0C, 32'h0000_5542, "R8 start with soft reset");
        rd('h08, 32'h0, "R8 control cleared with start");
        wait_neg(20);
        check({31'b0, irq}, 1, "R8 seed completes after combined write");
        wr('h04, 32'h10);
        // R5 mask
        wr('h08, 32'h20);
        wr('h04, 32'h1);
        wait_neg(20);
        check({31'b0, irq}, 0, "R5 masked completion");
        rd('h0C, 32'h0000_5571, "R5 done flag despite mask");
        // R9 restart
        wr('h04, 32'h40);
        wr('h04, 32'h2);
        wait_neg(7);
        wr('h04, 32'h2);
        wait_neg(15);
        rd('h0C, 32'h0000_5542, "R9 still running after restart");
        rd('h0C, 32'h0000_5561, "R9 done after restarted count");
        wait_neg(3);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule